// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address. It walks a page table that lives in memory and has two levels. A request brings in the virtual address and the base of the first-level table. The walker then issues one or two word reads on a simple memory read port. It finishes with a single response. That response carries either the translated physical address or a fault indication.

Three mapping granules are decoded. A first-level entry can map a whole 1 MiB region directly, or it can point to a second-level table. A second-level entry maps either a 64 KiB region or a 4 KiB region. The low two bits of every entry select its kind. When a walk ends in a fault, the response carries the virtual address that faulted. A read error reported by memory on either level ends the walk with a bus-error mark.

Only one walk is in progress at any time. No entries are cached and no permissions are checked.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is high. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. From that edge until the response cycle, `req_ready` stays low. Exactly one response follows each accepted request.
- R2: The first read is issued at address `req_root + req_vaddr[31:20]*4`.
- R3: A first-level entry whose bits [1:0] are 00 or 11 ends the walk after one read. The response then has `rsp_fault`=1, `rsp_buserr`=0 and `rsp_addr` equal to the virtual address.
- R4: A first-level entry with bits [1:0]=10 ends the walk after one read. It returns `rsp_addr = {entry[31:20], va[19:0]}` with `rsp_fault`=0.
- R5: A first-level entry with bits [1:0]=01 causes a second read. That read is at `(entry & 0xFFFFFC00) + va[19:12]*4`.
- R6: A second-level entry with bits [1:0]=00 gives a fault response with `rsp_addr` equal to the virtual address and `rsp_buserr`=0.
- R7: A second-level entry with bits [1:0]=01 returns `{entry[31:16], va[15:0]}`.
- R8: A second-level entry with bit 1 set, whether its bits [1:0] are 10 or 11, returns `{entry[31:12], va[11:0]}`.
- R9: If `mem_rsp_err` is high with a response on either read, the walk ends at once. The response has `rsp_fault`=1, `rsp_buserr`=1 and `rsp_addr` equal to the virtual address.
- R10: `rsp_valid` is high for exactly one cycle per walk. While `mem_rd_valid` is high and `mem_rd_ready` is low, the read request stays up and `mem_rd_addr` does not change.
- R11: Reset is synchronous and active high. During reset and on the cycle after it, `mem_rd_valid` and `rsp_valid` are low, even if reset arrives in the middle of a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Base address of the first-level table |
| mem_rd_valid | output | 1 | Word read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word that was read |
| mem_rsp_err | input | 1 | Read ended in error |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 32 | Physical address, or the faulting virtual address |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_buserr | output | 1 | The fault came from a memory read error |

## Verification
The hardest situation to reach from the ports is a second-level read that fails or faults. To get there, the first-level entry must link correctly, the first read must be accepted, and only then can the second read misbehave. The bench's memory model supplies a separate first-level word and second-level word for each vector, plus an error flag for each of the two reads. It also holds every read request off for one cycle before accepting it. This makes it possible to watch the second-level address being computed, and to check that the request is held, on each walk that links.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  parameter int VA_W     = 32;
  parameter int SECT_LSB = 20;
  parameter int LPG_LSB  = 16;
  parameter int SPG_LSB  = 12;
  parameter int L2_ALIGN = 10;

  localparam int L1_IDX_W = VA_W - SECT_LSB;
  localparam int L2_IDX_W = SECT_LSB - SPG_LSB;

  typedef logic [VA_W-1:0] word_t;

  typedef enum logic [1:0] {
    ENT_FAULT,
    ENT_LINK,
    ENT_LEAF
  } ent_kind_t;
endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter bit SECOND = 1'b0
) (
  input  ptw_pkg::word_t     entry,
  input  ptw_pkg::word_t     va,
  output ptw_pkg::ent_kind_t kind,
  output ptw_pkg::word_t     leaf_pa,
  output ptw_pkg::word_t     next_base
);
  import ptw_pkg::*;

  generate
    if (!SECOND) begin : g_first
      always_comb begin
        kind      = ENT_FAULT;
        leaf_pa   = {entry[VA_W-1:SECT_LSB], va[SECT_LSB-1:0]};
        next_base = {entry[VA_W-1:L2_ALIGN], {L2_ALIGN{1'b0}}};
        unique case (entry[1:0])
          2'b01:   kind = ENT_LINK;
          2'b10:   kind = ENT_LEAF;
          default: kind = ENT_FAULT;
        endcase
      end
    end else begin : g_second
      always_comb begin
        next_base = '0;
        if (entry[1]) begin
          kind    = ENT_LEAF;
          leaf_pa = {entry[VA_W-1:SPG_LSB], va[SPG_LSB-1:0]};
        end else if (entry[0]) begin
          kind    = ENT_LEAF;
          leaf_pa = {entry[VA_W-1:LPG_LSB], va[LPG_LSB-1:0]};
        end else begin
          kind    = ENT_FAULT;
          leaf_pa = '0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ptw_rd_port.sv
module ptw_rd_port (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  ptw_pkg::word_t start_addr,
  output logic           mem_rd_valid,
  output ptw_pkg::word_t mem_rd_addr,
  input  logic           mem_rd_ready,
  input  logic           mem_rsp_valid,
  input  ptw_pkg::word_t mem_rsp_data,
  input  logic           mem_rsp_err,
  output logic           rd_done,
  output ptw_pkg::word_t rd_data,
  output logic           rd_err
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      pending      <= 1'b0;
    end else begin
      if (start) begin
        mem_rd_valid <= 1'b1;
        mem_rd_addr  <= start_addr;
      end else if (mem_rd_valid && mem_rd_ready) begin
        mem_rd_valid <= 1'b0;
      end
      if (mem_rd_valid && mem_rd_ready)
        pending <= 1'b1;
      else if (pending && mem_rsp_valid)
        pending <= 1'b0;
    end
  end

  assign rd_done = pending && mem_rsp_valid;
  assign rd_data = mem_rsp_data;
  assign rd_err  = mem_rsp_err;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [31:0] req_root,
  output logic        mem_rd_valid,
  input  logic        mem_rd_ready,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        rsp_valid,
  output logic [31:0] rsp_addr,
  output logic        rsp_fault,
  output logic        rsp_buserr
);
  import ptw_pkg::*;

  typedef enum logic [1:0] {S_IDLE, S_LVL1, S_LVL2} state_t;

  state_t    state;
  word_t     va_q;
  logic      start;
  word_t     start_addr;
  logic      rd_done, rd_err;
  word_t     rd_data;
  ent_kind_t k1, k2;
  word_t     pa1, pa2, base1, base2;
  word_t     l1_addr, l2_addr;

  ptw_rd_port u_port (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .rd_done(rd_done), .rd_data(rd_data), .rd_err(rd_err)
  );

  ptw_entry_decode #(.SECOND(1'b0)) u_dec1 (
    .entry(rd_data), .va(va_q), .kind(k1), .leaf_pa(pa1), .next_base(base1)
  );

  ptw_entry_decode #(.SECOND(1'b1)) u_dec2 (
    .entry(rd_data), .va(va_q), .kind(k2), .leaf_pa(pa2), .next_base(base2)
  );

  assign l1_addr = req_root +
    {{(VA_W-L1_IDX_W-2){1'b0}}, req_vaddr[VA_W-1:SECT_LSB], 2'b00};
  assign l2_addr = base1 +
    {{(VA_W-L2_IDX_W-2){1'b0}}, va_q[SECT_LSB-1:SPG_LSB], 2'b00};
  assign req_ready = (state == S_IDLE);

  always_comb begin
    start      = 1'b0;
    start_addr = l1_addr;
    if (state == S_IDLE && req_valid) begin
      start = 1'b1;
    end else if (state == S_LVL1 && rd_done && !rd_err && k1 == ENT_LINK) begin
      start      = 1'b1;
      start_addr = l2_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      va_q       <= '0;
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_fault  <= 1'b0;
      rsp_buserr <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          va_q  <= req_vaddr;
          state <= S_LVL1;
        end
        S_LVL1: if (rd_done) begin
          if (rd_err || k1 != ENT_LINK) begin
            state      <= S_IDLE;
            rsp_valid  <= 1'b1;
            rsp_buserr <= rd_err;
            rsp_fault  <= rd_err || (k1 == ENT_FAULT);
            rsp_addr   <= (rd_err || k1 == ENT_FAULT) ? va_q : pa1;
          end else begin
            state <= S_LVL2;
          end
        end
        S_LVL2: if (rd_done) begin
          state      <= S_IDLE;
          rsp_valid  <= 1'b1;
          rsp_buserr <= rd_err;
          rsp_fault  <= rd_err || (k2 == ENT_FAULT);
          rsp_addr   <= (rd_err || k2 == ENT_FAULT) ? va_q : pa2;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        rsp_valid,
  input logic [31:0] rsp_addr,
  input logic        rsp_fault,
  input logic        rsp_buserr
);
  logic        busy;
  logic [31:0] va_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      va_seen <= '0;
    end else if (req_valid && req_ready) begin
      busy    <= 1'b1;
      va_seen <= req_vaddr;
    end else if (rsp_valid) begin
      busy <= 1'b0;
    end
  end

  // R1
  walk_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !rsp_valid |-> !req_ready);
  // R1
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> busy);
  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
  // R9
  buserr_fault_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_buserr |-> rsp_fault);
  // R3
  fault_va_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_addr == va_seen);
  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mem_rd_valid && !rsp_valid);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
  .rsp_buserr(rsp_buserr)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_root = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic        rsp_buserr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root(req_root),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .rsp_buserr(rsp_buserr)
  );

  typedef struct packed {
    logic [7:0]  tag;
    logic [31:0] va;
    logic [31:0] root;
    logic [31:0] e1;
    logic [31:0] e2;
    logic        err1;
    logic        err2;
    logic [1:0]  nreads;
    logic [31:0] a1;
    logic [31:0] a2;
    logic [31:0] xaddr;
    logic        xfault;
    logic        xbus;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R4 section
    '{8'd4, 32'h1234_5678, 32'h0010_0000, 32'hABC0_0002, 32'h0, 1'b0, 1'b0, 2'd1,
      32'h0010_048C, 32'h0, 32'hABC4_5678, 1'b0, 1'b0},
    // R3 first-level type 00
    '{8'd3, 32'h8000_1000, 32'h0010_0000, 32'h0000_0000, 32'h0, 1'b0, 1'b0, 2'd1,
      32'h0010_2000, 32'h0, 32'h8000_1000, 1'b1, 1'b0},
    // R3 first-level type 11
    '{8'd3, 32'hFFF0_0004, 32'h0010_0000, 32'h1234_5673, 32'h0, 1'b0, 1'b0, 2'd1,
      32'h0010_3FFC, 32'h0, 32'hFFF0_0004, 1'b1, 1'b0},
    // R7 large page through a link (R5)
    '{8'd7, 32'h0045_6789, 32'h0010_0000, 32'h0200_0401, 32'h7654_0001, 1'b0, 1'b0, 2'd2,
      32'h0010_0010, 32'h0200_0558, 32'h7654_6789, 1'b0, 1'b0},
    // R8 small page type 10, link low bits masked (R5)
    '{8'd8, 32'h00A0_BCDE, 32'h0010_0000, 32'h0300_07F1, 32'h1357_9002, 1'b0, 1'b0, 2'd2,
      32'h0010_0028, 32'h0300_042C, 32'h1357_9CDE, 1'b0, 1'b0},
    // R8 small page type 11, last second-level index
    '{8'd8, 32'hC00F_F123, 32'h0010_0000, 32'h0400_0001, 32'h2468_A003, 1'b0, 1'b0, 2'd2,
      32'h0010_3000, 32'h0400_03FC, 32'h2468_A123, 1'b0, 1'b0},
    // R6 second-level fault
    '{8'd6, 32'h0071_2000, 32'h0010_0000, 32'h0500_0001, 32'hFFFF_F000, 1'b0, 1'b0, 2'd2,
      32'h0010_001C, 32'h0500_0048, 32'h0071_2000, 1'b1, 1'b0},
    // R9 error on first read
    '{8'd9, 32'h0990_0000, 32'h0010_0000, 32'h0000_0002, 32'h0, 1'b1, 1'b0, 2'd1,
      32'h0010_0264, 32'h0, 32'h0990_0000, 1'b1, 1'b1},
    // R9 error on second read
    '{8'd9, 32'h0001_3000, 32'h0010_0000, 32'h0600_0001, 32'h0000_1002, 1'b0, 1'b1, 2'd2,
      32'h0010_0000, 32'h0600_004C, 32'h0001_3000, 1'b1, 1'b1},
    // R2 different root, section
    '{8'd2, 32'h0000_0000, 32'h7FFF_C000, 32'h0010_0002, 32'h0, 1'b0, 1'b0, 2'd1,
      32'h7FFF_C000, 32'h0, 32'h0010_0000, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int reads = 0;
    int stall = 0;
    bit got = 0;
    bit saw_ready = 0;
    bit stable_ok = 1;
    logic [31:0] a1 = '0;
    logic [31:0] a2 = '0;
    logic [31:0] held = '0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = v.va; req_root = v.root;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 60 && !got; c++) begin
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
      if (rsp_valid) begin
        got = 1;
      end else begin
        if (req_ready) saw_ready = 1;
        if (mem_rd_ready) begin
          mem_rd_ready  = 1'b0;
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = (reads == 1) ? v.e1 : v.e2;
          mem_rsp_err   = (reads == 1) ? v.err1 : v.err2;
        end else if (mem_rd_valid) begin
          if (stall == 0) begin
            held = mem_rd_addr; stall = 1;
          end else begin
            if (mem_rd_addr !== held) stable_ok = 0;
            if (reads == 0) a1 = mem_rd_addr; else a2 = mem_rd_addr;
            mem_rd_ready = 1'b1; reads++; stall = 0;
          end
        end
        @(negedge clk);
      end
    end
    chk(got, $sformatf("R%0d response arrives", v.tag), {31'd0, got}, 32'd1);
    chk(!saw_ready, "R1 req_ready low during walk", {31'd0, saw_ready}, 32'd0);
    chk(stable_ok, "R10 read address held while stalled", a1, held);
    chk(a1 === v.a1, "R2 first read address", a1, v.a1);
    chk(reads == v.nreads, $sformatf("R%0d read count", v.tag), reads, {30'd0, v.nreads});
    if (v.nreads == 2)
      chk(a2 === v.a2, "R5 second read address", a2, v.a2);
    chk(rsp_addr === v.xaddr, $sformatf("R%0d rsp_addr", v.tag), rsp_addr, v.xaddr);
    chk(rsp_fault === v.xfault, $sformatf("R%0d rsp_fault", v.tag),
        {31'd0, rsp_fault}, {31'd0, v.xfault});
    chk(rsp_buserr === v.xbus, $sformatf("R%0d rsp_buserr", v.tag),
        {31'd0, rsp_buserr}, {31'd0, v.xbus});
    mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R10 rsp_valid one cycle", {31'd0, rsp_valid}, 32'd0);
    chk(req_ready === 1'b1, "R1 ready again after walk", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 state during reset
    chk(mem_rd_valid === 1'b0, "R11 rd_valid in reset", {31'd0, mem_rd_valid}, 32'd0);
    chk(rsp_valid === 1'b0, "R11 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11 reset in the middle of a walk
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0123_4567; req_root = 32'h0010_0000;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_rd_valid === 1'b1, "R11 walk started", {31'd0, mem_rd_valid}, 32'd1);
    chk(req_ready === 1'b0, "R1 busy before reset", {31'd0, req_ready}, 32'd0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_rd_valid === 1'b0, "R11 read dropped", {31'd0, mem_rd_valid}, 32'd0);
    chk(rsp_valid === 1'b0, "R11 no response", {31'd0, rsp_valid}, 32'd0);
    chk(req_ready === 1'b1, "R11 idle after reset", {31'd0, req_ready}, 32'd1);

    // walk after the mid-walk reset behaves normally
    run_vec(VECS[3]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule